// File: doc/BRIEF.md
# Shadowed Page Memory Command Controller

This block sits between a byte-wide host register port and a small non-volatile byte array. The array holds three 32-byte pages. Page 0 is mirrored by a 32-byte working RAM that the host reads and writes freely. Pages 1 and 2 are read directly through the host port and can only be changed by commands. The host loads a data register and an address register and then writes a code into the command register. The controller then performs one of four operations, each with its own busy window: a single-byte program, a RAM-to-page-0 copy, a page-0-to-RAM copy, or a page erase. Programming can only clear bits: the stored byte becomes the old byte AND the new data. To replace data, the page is erased to all ones first and then programmed again.

After every reset the controller runs a load sequence. It copies page 0 into the RAM and copies three non-volatile offset bytes into host-visible offset registers. Host reads are combinational from the address. A write takes effect on the clock edge where host_req_i and host_we_i are both high. Busy durations are given as clock-cycle parameters. The non-volatile array is external: the controller drives an address, a write strobe and write data, and it receives read data in the same cycle.

Top module: `flash_shadow_ctrl`

## Requirements
- R1: While reset is held and for the 35 cycles after it is released, busy_o is high. When busy_o falls, RAM byte i (0x00–0x1F) equals non-volatile byte i, and offset registers 0x75–0x77 equal non-volatile bytes 0x75–0x77. The command register reads 0x00.
- R2: Host address map, 7-bit. 0x00–0x1F is RAM (read/write). 0x6F is the program-data register, 0x70 the program-address register, 0x75–0x77 the offset registers (all read/write, reset 0x00). 0x62 is the command register. 0x20–0x5F reads the non-volatile byte at the same address. Every other address reads 0x00.
- R3: Code 0x0F programs one byte. At its last busy cycle, the non-volatile byte at the program address becomes old AND program-data. This applies only if the program address is 0x00–0x5F or 0x75–0x77. Any other program address leaves the array unchanged. No write ever sets a bit that was clear.
- R4: Code 0x22 replaces each byte i of page 0 (non-volatile 0x00–0x1F) with old AND RAM byte i.
- R5: Code 0x23 copies non-volatile bytes 0x00–0x1F into RAM bytes 0–31.
- R6: Codes 0x30, 0x31 and 0x32 set all 32 bytes of page 0, 1 and 2 respectively to 0xFF.
- R7: busy_o rises on the edge that accepts a command write. It stays high for exactly PROG_CYC cycles (0x0F), XFER_CYC cycles (0x22, 0x23) or ERASE_CYC cycles (0x30–0x32). While busy, the command register reads the running code. Once idle, it reads 0x00.
- R8: While busy_o is high, every host write is ignored. This includes a command write in the final busy cycle. Reads of 0x20–0x5F return 0xFF while busy.
- R9: A write of any other code to 0x62 is ignored. busy_o stays low, the command register stays 0x00, and no memory changes.
- R10: Host writes to 0x20–0x5F are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_req_i | input | 1 | Host access strobe |
| host_we_i | input | 1 | Host write when high with host_req_i |
| host_addr_i | input | 7 | Host register address |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Combinational read data for host_addr_i |
| busy_o | output | 1 | Operation or load sequence in progress |
| nvm_addr_o | output | 7 | Non-volatile array byte address |
| nvm_we_o | output | 1 | Non-volatile byte write strobe |
| nvm_wdata_o | output | 8 | Non-volatile write data |
| nvm_rdata_i | input | 8 | Non-volatile read data at nvm_addr_o, same cycle |

## Verification
The two functions that can meet in one cycle are the completion of a running operation and a new host command write. When an operation finishes, the controller drops busy on the same edge at which the host may be issuing its next command. The bench provokes this by tracking its own model's busy counter. It issues an erase command in exactly the last busy cycle of a page copy, then issues the same command again on the following cycle. It judges that the first write was dropped and the second was accepted by comparing busy_o, the command readback and the whole array against the model on every clock.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int ADDR_W     = 7;
  localparam int DATA_W     = 8;
  localparam int PAGE_BYTES = 32;
  localparam int IDX_W      = $clog2(PAGE_BYTES);
  localparam int OFS_BYTES  = 3;
  localparam int OFS_W      = $clog2(OFS_BYTES);

  localparam logic [ADDR_W-1:0] A_RAM_END   = 7'h1F;
  localparam logic [ADDR_W-1:0] A_FLASH_END = 7'h5F;
  localparam logic [ADDR_W-1:0] A_CMD       = 7'h62;
  localparam logic [ADDR_W-1:0] A_PDATA     = 7'h6F;
  localparam logic [ADDR_W-1:0] A_PADDR     = 7'h70;
  localparam logic [ADDR_W-1:0] A_OFS0      = 7'h75;

  localparam logic [DATA_W-1:0] C_PROG   = 8'h0F;
  localparam logic [DATA_W-1:0] C_R2F    = 8'h22;
  localparam logic [DATA_W-1:0] C_F2R    = 8'h23;
  localparam logic [DATA_W-1:0] C_ERASE0 = 8'h30;
  localparam logic [DATA_W-1:0] C_ERASE1 = 8'h31;
  localparam logic [DATA_W-1:0] C_ERASE2 = 8'h32;

  typedef enum logic [2:0] {
    OP_IDLE, OP_BOOT, OP_PROG, OP_R2F, OP_F2R, OP_ERASE
  } op_e;

  function automatic op_e code_op(logic [DATA_W-1:0] c);
    case (c)
      C_PROG:                       return OP_PROG;
      C_R2F:                        return OP_R2F;
      C_F2R:                        return OP_F2R;
      C_ERASE0, C_ERASE1, C_ERASE2: return OP_ERASE;
      default:                      return OP_IDLE;
    endcase
  endfunction

  function automatic logic prog_addr_ok(logic [ADDR_W-1:0] a);
    return (a <= A_FLASH_END) ||
           (a >= A_OFS0 && a < A_OFS0 + ADDR_W'(OFS_BYTES));
  endfunction
endpackage

// File: rtl/fsr_shadow_ram.sv
module fsr_shadow_ram
  import fsr_pkg::*;
#(
  parameter int DEPTH = PAGE_BYTES,
  parameter int IW    = $clog2(DEPTH),
  parameter int DW    = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_we_i,
  input  logic [IW-1:0] host_idx_i,
  input  logic [DW-1:0] host_wdata_i,
  input  logic          seq_we_i,
  input  logic [IW-1:0] seq_idx_i,
  input  logic [DW-1:0] seq_wdata_i,
  output logic [DW-1:0] host_rdata_o,
  output logic [DW-1:0] seq_rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_byte
    logic [DW-1:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  byte_q <= '0;
      else if (seq_we_i && seq_idx_i == IW'(i))     byte_q <= seq_wdata_i;
      else if (host_we_i && host_idx_i == IW'(i))   byte_q <= host_wdata_i;
    end
    assign mem[i] = byte_q;
  end

  assign host_rdata_o = mem[host_idx_i];
  assign seq_rdata_o  = mem[seq_idx_i];

  AST_SINGLE_WRITER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_we_i && seq_we_i)); // R8
endmodule

// File: rtl/fsr_host_regs.sv
module fsr_host_regs
  import fsr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ofs_we_i,
  input  logic [OFS_W-1:0]  ofs_idx_i,
  input  logic [DATA_W-1:0] ofs_wdata_i,
  input  logic [DATA_W-1:0] ram_rdata_i,
  input  logic [DATA_W-1:0] nvm_rdata_i,
  input  logic [DATA_W-1:0] cmd_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ram_we_o,
  output logic              start_o,
  output logic [DATA_W-1:0] code_o,
  output logic [DATA_W-1:0] pdata_o,
  output logic [ADDR_W-1:0] paddr_o
);
  logic              wr;
  logic [DATA_W-1:0] pdata_q;
  logic [ADDR_W-1:0] paddr_q;
  logic [DATA_W-1:0] ofs_q [OFS_BYTES];

  assign wr       = req_i && we_i && !busy_i;
  assign ram_we_o = wr && addr_i <= A_RAM_END;
  assign start_o  = wr && addr_i == A_CMD && code_op(wdata_i) != OP_IDLE;
  assign code_o   = wdata_i;
  assign pdata_o  = pdata_q;
  assign paddr_o  = paddr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pdata_q <= '0;
      paddr_q <= '0;
    end else if (wr) begin
      if (addr_i == A_PDATA) pdata_q <= wdata_i;
      if (addr_i == A_PADDR) paddr_q <= wdata_i[ADDR_W-1:0];
    end
  end

  for (genvar k = 0; k < OFS_BYTES; k++) begin : g_ofs
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     ofs_q[k] <= '0;
      else if (ofs_we_i && ofs_idx_i == OFS_W'(k))     ofs_q[k] <= ofs_wdata_i;
      else if (wr && addr_i == A_OFS0 + ADDR_W'(k))    ofs_q[k] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i <= A_RAM_END)        rdata_o = ram_rdata_i;
    else if (addr_i <= A_FLASH_END) rdata_o = busy_i ? '1 : nvm_rdata_i;
    else if (addr_i == A_CMD)       rdata_o = cmd_i;
    else if (addr_i == A_PDATA)     rdata_o = pdata_q;
    else if (addr_i == A_PADDR)     rdata_o = {1'b0, paddr_q};
    else begin
      for (int k = 0; k < OFS_BYTES; k++)
        if (addr_i == A_OFS0 + ADDR_W'(k)) rdata_o = ofs_q[k];
    end
  end

  AST_PDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && req_i && we_i && addr_i == A_PDATA) |=> $stable(pdata_q)); // R8
  AST_PADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && req_i && we_i && addr_i == A_PADDR) |=> $stable(paddr_q)); // R8
endmodule

// File: rtl/fsr_sequencer.sv
module fsr_sequencer
  import fsr_pkg::*;
#(
  parameter int PROG_CYC  = 12,
  parameter int XFER_CYC  = 48,
  parameter int ERASE_CYC = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] code_i,
  input  logic [DATA_W-1:0] pdata_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] ram_rdata_i,
  input  logic [DATA_W-1:0] nvm_rdata_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] cmd_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              ram_we_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  output logic              ofs_we_o,
  output logic [OFS_W-1:0]  ofs_idx_o,
  output logic [ADDR_W-1:0] nvm_addr_o,
  output logic              nvm_we_o,
  output logic [DATA_W-1:0] nvm_wdata_o
);
  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int BOOT_CYC = PAGE_BYTES + OFS_BYTES;
  localparam int MAXD     = imax(imax(PROG_CYC, XFER_CYC), imax(ERASE_CYC, BOOT_CYC));
  localparam int CW       = $clog2(MAXD + 1);
  localparam logic [CW-1:0] PB_C = CW'(PAGE_BYTES);
  localparam logic [CW-1:0] BT_C = CW'(BOOT_CYC);

  op_e               op_q;
  logic [CW-1:0]     cnt_q, dur;
  logic [1:0]        page_q;
  logic [DATA_W-1:0] cmd_q;
  logic              last;

  always_comb begin
    case (op_q)
      OP_BOOT:       dur = BT_C;
      OP_PROG:       dur = CW'(PROG_CYC);
      OP_R2F, OP_F2R: dur = CW'(XFER_CYC);
      OP_ERASE:      dur = CW'(ERASE_CYC);
      default:       dur = '1;
    endcase
  end

  assign busy_o = op_q != OP_IDLE;
  assign last   = busy_o && cnt_q == dur - 1'b1;
  assign cmd_o  = cmd_q;
  assign idx_o  = cnt_q[IDX_W-1:0];
  assign ofs_idx_o   = OFS_W'(cnt_q - PB_C);
  assign ram_wdata_o = nvm_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_BOOT;
      cnt_q  <= '0;
      page_q <= '0;
      cmd_q  <= '0;
    end else if (busy_o) begin
      if (last) begin
        op_q  <= OP_IDLE;
        cnt_q <= '0;
        cmd_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (start_i) begin
      op_q   <= code_op(code_i);
      cnt_q  <= '0;
      page_q <= code_i[1:0];
      cmd_q  <= code_i;
    end
  end

  // One array byte per cycle over the first PAGE_BYTES counts, then wait out the window.
  always_comb begin
    nvm_addr_o  = host_addr_i;
    nvm_we_o    = 1'b0;
    nvm_wdata_o = '0;
    ram_we_o    = 1'b0;
    ofs_we_o    = 1'b0;
    case (op_q)
      OP_BOOT: begin
        if (cnt_q < PB_C) begin
          nvm_addr_o = {2'b00, idx_o};
          ram_we_o   = 1'b1;
        end else if (cnt_q < BT_C) begin
          nvm_addr_o = A_OFS0 + ADDR_W'(ofs_idx_o);
          ofs_we_o   = 1'b1;
        end
      end
      OP_PROG: begin
        nvm_addr_o = paddr_i;
        if (last && prog_addr_ok(paddr_i)) begin
          nvm_we_o    = 1'b1;
          nvm_wdata_o = nvm_rdata_i & pdata_i;
        end
      end
      OP_R2F: if (cnt_q < PB_C) begin
        nvm_addr_o  = {2'b00, idx_o};
        nvm_we_o    = 1'b1;
        nvm_wdata_o = nvm_rdata_i & ram_rdata_i;
      end
      OP_F2R: if (cnt_q < PB_C) begin
        nvm_addr_o = {2'b00, idx_o};
        ram_we_o   = 1'b1;
      end
      OP_ERASE: if (cnt_q < PB_C) begin
        nvm_addr_o  = {page_q, idx_o};
        nvm_we_o    = 1'b1;
        nvm_wdata_o = '1;
      end
      default: ;
    endcase
  end

  AST_START_ONLY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o); // R8
  AST_WRITE_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nvm_we_o |-> busy_o); // R7
  AST_CNT_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> cnt_q < dur); // R7
  AST_CMD_ZERO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> cmd_q == '0); // R7
  AST_NO_BIT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nvm_we_o && op_q != OP_ERASE) |-> (nvm_wdata_o & ~nvm_rdata_i) == '0); // R3
endmodule

// File: rtl/flash_shadow_ctrl.sv
module flash_shadow_ctrl
  import fsr_pkg::*;
#(
  parameter int PROG_CYC  = 12,
  parameter int XFER_CYC  = 48,
  parameter int ERASE_CYC = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_req_i,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] nvm_addr_o,
  output logic              nvm_we_o,
  output logic [DATA_W-1:0] nvm_wdata_o,
  input  logic [DATA_W-1:0] nvm_rdata_i
);
  logic              busy, ram_host_we, ram_seq_we, start, ofs_we;
  logic [DATA_W-1:0] code, pdata, cmd, ram_host_rd, ram_seq_rd, ram_seq_wd;
  logic [ADDR_W-1:0] paddr;
  logic [IDX_W-1:0]  seq_idx;
  logic [OFS_W-1:0]  ofs_idx;

  assign busy_o = busy;

  fsr_host_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .busy_i      (busy),
    .req_i       (host_req_i),
    .we_i        (host_we_i),
    .addr_i      (host_addr_i),
    .wdata_i     (host_wdata_i),
    .ofs_we_i    (ofs_we),
    .ofs_idx_i   (ofs_idx),
    .ofs_wdata_i (nvm_rdata_i),
    .ram_rdata_i (ram_host_rd),
    .nvm_rdata_i (nvm_rdata_i),
    .cmd_i       (cmd),
    .rdata_o     (host_rdata_o),
    .ram_we_o    (ram_host_we),
    .start_o     (start),
    .code_o      (code),
    .pdata_o     (pdata),
    .paddr_o     (paddr)
  );

  fsr_shadow_ram #(.DEPTH(PAGE_BYTES)) u_ram (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_we_i    (ram_host_we),
    .host_idx_i   (host_addr_i[IDX_W-1:0]),
    .host_wdata_i (host_wdata_i),
    .seq_we_i     (ram_seq_we),
    .seq_idx_i    (seq_idx),
    .seq_wdata_i  (ram_seq_wd),
    .host_rdata_o (ram_host_rd),
    .seq_rdata_o  (ram_seq_rd)
  );

  fsr_sequencer #(
    .PROG_CYC (PROG_CYC),
    .XFER_CYC (XFER_CYC),
    .ERASE_CYC(ERASE_CYC)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .code_i      (code),
    .pdata_i     (pdata),
    .paddr_i     (paddr),
    .host_addr_i (host_addr_i),
    .ram_rdata_i (ram_seq_rd),
    .nvm_rdata_i (nvm_rdata_i),
    .busy_o      (busy),
    .cmd_o       (cmd),
    .idx_o       (seq_idx),
    .ram_we_o    (ram_seq_we),
    .ram_wdata_o (ram_seq_wd),
    .ofs_we_o    (ofs_we),
    .ofs_idx_o   (ofs_idx),
    .nvm_addr_o  (nvm_addr_o),
    .nvm_we_o    (nvm_we_o),
    .nvm_wdata_o (nvm_wdata_o)
  );
endmodule

// File: tb/tb_flash_shadow_ctrl.sv
module tb_flash_shadow_ctrl;
  localparam int PROG  = 12;
  localparam int XFER  = 48;
  localparam int ERASE = 40;
  localparam int BOOT  = 35;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       h_req = 1'b0, h_we = 1'b0;
  logic [6:0] h_addr = '0;
  logic [7:0] h_wdata = '0, h_rdata;
  logic       busy, nvm_we;
  logic [6:0] nvm_addr;
  logic [7:0] nvm_wdata, nvm_rdata;
  logic [7:0] nv [128];

  always #4 clk = ~clk;

  flash_shadow_ctrl #(.PROG_CYC(PROG), .XFER_CYC(XFER), .ERASE_CYC(ERASE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .host_req_i(h_req), .host_we_i(h_we),
    .host_addr_i(h_addr), .host_wdata_i(h_wdata), .host_rdata_o(h_rdata),
    .busy_o(busy), .nvm_addr_o(nvm_addr), .nvm_we_o(nvm_we),
    .nvm_wdata_o(nvm_wdata), .nvm_rdata_i(nvm_rdata));

  assign nvm_rdata = nv[nvm_addr];
  always @(posedge clk) if (nvm_we) nv[nvm_addr] <= nvm_wdata;

  // reference model
  logic [7:0] m_nv [128];
  logic [7:0] m_ram [32];
  logic [7:0] m_ofs [3];
  logic [7:0] m_cmd, m_pd;
  logic [6:0] m_pa;
  int m_busy, m_cnt, m_dur, m_op, m_page;
  string m_tag = "R1";
  int checks = 0, failures = 0, wd = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mread(input logic [6:0] a);
    if (a <= 7'h1F) return m_ram[a[4:0]];
    if (a <= 7'h5F) return m_busy ? 8'hFF : m_nv[a];
    if (a == 7'h62) return m_cmd;
    if (a == 7'h6F) return m_pd;
    if (a == 7'h70) return {1'b0, m_pa};
    if (a >= 7'h75 && a <= 7'h77) return m_ofs[a - 7'h75];
    return 8'h00;
  endfunction

  task automatic m_reset();
    m_busy = 1; m_cnt = 0; m_dur = BOOT; m_op = 1; m_cmd = 0; m_pd = 0; m_pa = 0;
    m_tag = "R1";
    for (int i = 0; i < 32; i++) m_ram[i] = 0;
    for (int k = 0; k < 3; k++) m_ofs[k] = 0;
  endtask

  task automatic m_finish();
    case (m_op)
      1: begin
        for (int i = 0; i < 32; i++) m_ram[i] = m_nv[i];
        for (int k = 0; k < 3; k++) m_ofs[k] = m_nv[8'h75 + k];
      end
      2: if (m_pa <= 7'h5F || (m_pa >= 7'h75 && m_pa <= 7'h77)) m_nv[m_pa] = m_nv[m_pa] & m_pd;
      3: for (int i = 0; i < 32; i++) m_nv[i] = m_nv[i] & m_ram[i];
      4: for (int i = 0; i < 32; i++) m_ram[i] = m_nv[i];
      5: for (int i = 0; i < 32; i++) m_nv[m_page*32 + i] = 8'hFF;
      default: ;
    endcase
    m_busy = 0; m_cmd = 0; m_op = 0;
  endtask

  task automatic m_edge(input bit req, input bit we, input logic [6:0] a, input logic [7:0] d);
    if (m_busy) begin
      m_cnt++;
      if (m_cnt == m_dur) m_finish();
    end else if (req && we) begin
      if (a <= 7'h1F) m_ram[a[4:0]] = d;
      else if (a == 7'h6F) m_pd = d;
      else if (a == 7'h70) m_pa = d[6:0];
      else if (a >= 7'h75 && a <= 7'h77) m_ofs[a - 7'h75] = d;
      else if (a == 7'h62) begin
        m_op = 0;
        case (d)
          8'h0F: begin m_op = 2; m_dur = PROG; m_tag = "R3"; end
          8'h22: begin m_op = 3; m_dur = XFER; m_tag = "R4"; end
          8'h23: begin m_op = 4; m_dur = XFER; m_tag = "R5"; end
          8'h30, 8'h31, 8'h32: begin m_op = 5; m_dur = ERASE; m_page = d - 8'h30; m_tag = "R6"; end
          default: ;
        endcase
        if (m_op != 0) begin m_busy = 1; m_cnt = 0; m_cmd = d; end
      end
    end
  endtask

  // one clock: drive at negedge, check reads, step model at posedge, check at negedge
  task automatic cyc(input bit req, input bit we, input logic [6:0] a, input logic [7:0] d,
                     input string tag = "");
    string t;
    h_req = req; h_we = we; h_addr = a; h_wdata = d;
    #1;
    t = tag;
    if (t == "") t = (a >= 7'h20 && a <= 7'h5F && m_busy != 0) ? "R8" : (a == 7'h62 ? "R7" : "R2");
    if (!(m_busy != 0 && (a <= 7'h1F || (a >= 7'h75 && a <= 7'h77))))
      chk(h_rdata == mread(a), t, h_rdata, mread(a));
    @(posedge clk);
    m_edge(req, we, a, d);
    @(negedge clk);
    h_req = 0; h_we = 0;
    chk(busy == (m_busy != 0), "R7", busy, m_busy);
    if (m_busy == 0) begin
      int bad = -1;
      for (int i = 0; i < 128; i++) if (nv[i] !== m_nv[i] && bad < 0) bad = i;
      chk(bad < 0, m_tag, bad < 0 ? 0 : nv[bad], bad < 0 ? 0 : m_nv[bad]);
    end
  endtask

  task automatic wait_idle();
    while (m_busy != 0) cyc(0, 0, 7'h62, 0);
  endtask

  task automatic sweep(input string tag);
    for (int a = 0; a < 128; a++) cyc(0, 0, 7'(a), 0, tag);
  endtask

  task automatic run_cmd(input logic [7:0] c);
    cyc(1, 1, 7'h62, c);
    wait_idle();
  endtask

  task automatic do_reset();
    h_req = 0; h_we = 0;
    rst_n = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(busy == 1'b1, "R1", busy, 1);      // R1 reset state
      chk(nvm_we == 1'b0, "R1", nvm_we, 0);
    end
    m_reset();
    rst_n = 1;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=0", wd);
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) begin
      nv[i] = 8'((i * 73 + 29) ^ (i >> 2));
      m_nv[i] = nv[i];
    end
    m_reset();
    do_reset();
    wait_idle();
    sweep("R1");

    // R2 register file
    cyc(1, 1, 7'h03, 8'hA5, "R2");
    cyc(1, 1, 7'h6F, 8'h3C, "R2");
    cyc(1, 1, 7'h70, 8'h25, "R2");
    cyc(1, 1, 7'h76, 8'h11, "R2");
    cyc(0, 0, 7'h03, 0, "R2");
    cyc(0, 0, 7'h6F, 0, "R2");
    cyc(0, 0, 7'h70, 0, "R2");
    cyc(0, 0, 7'h76, 0, "R2");
    cyc(0, 0, 7'h7A, 0, "R2");

    // R10 direct writes to pages 1/2 dropped
    cyc(1, 1, 7'h21, 8'h00, "R10");
    cyc(0, 0, 7'h21, 0, "R10");
    cyc(1, 1, 7'h4E, 8'h00, "R10");
    cyc(0, 0, 7'h4E, 0, "R10");

    // R3 byte program, AND semantics
    cyc(1, 1, 7'h62, 8'h0F);
    cyc(0, 0, 7'h62, 0, "R7");
    cyc(0, 0, 7'h25, 0, "R8");
    wait_idle();
    cyc(0, 0, 7'h25, 0, "R3");
    cyc(1, 1, 7'h6F, 8'hC3, "R3");
    run_cmd(8'h0F);
    cyc(0, 0, 7'h25, 0, "R3");
    cyc(1, 1, 7'h70, 8'h76, "R3");
    cyc(1, 1, 7'h6F, 8'h5A, "R3");
    run_cmd(8'h0F);
    cyc(1, 1, 7'h70, 8'h65, "R3");
    run_cmd(8'h0F);
    cyc(1, 1, 7'h70, 8'h05, "R3");
    run_cmd(8'h0F);

    // R6 erase page 1 then reprogram
    run_cmd(8'h31);
    sweep("R6");
    cyc(1, 1, 7'h70, 8'h25, "R6");
    run_cmd(8'h0F);
    cyc(0, 0, 7'h25, 0, "R6");

    // R4 RAM to page 0, without and with erase
    for (int i = 0; i < 32; i++) cyc(1, 1, 7'(i), 8'((i * 29) ^ 8'h6C), "R4");
    run_cmd(8'h22);
    run_cmd(8'h30);
    run_cmd(8'h22);
    for (int i = 0; i < 32; i++) cyc(0, 0, 7'(i), 0, "R4");

    // R5 page 0 back into RAM
    for (int i = 0; i < 32; i += 3) cyc(1, 1, 7'(i), 8'h00, "R5");
    run_cmd(8'h23);
    for (int i = 0; i < 32; i++) cyc(0, 0, 7'(i), 0, "R5");

    // R9 unknown codes
    cyc(1, 1, 7'h62, 8'h55, "R9");
    chk(busy == 1'b0, "R9", busy, 0);
    cyc(0, 0, 7'h62, 0, "R9");
    cyc(1, 1, 7'h62, 8'h33, "R9");
    chk(busy == 1'b0, "R9", busy, 0);
    cyc(1, 1, 7'h62, 8'h00, "R9");
    chk(busy == 1'b0, "R9", busy, 0);
    cyc(0, 0, 7'h62, 0, "R9");

    // R8 writes while busy dropped, page reads masked
    cyc(1, 1, 7'h62, 8'h32);
    cyc(1, 1, 7'h6F, 8'h99, "R8");
    cyc(1, 1, 7'h00, 8'h77, "R8");
    cyc(1, 1, 7'h62, 8'h0F, "R8");
    cyc(0, 0, 7'h40, 0, "R8");
    cyc(0, 0, 7'h62, 0, "R8");
    wait_idle();
    cyc(0, 0, 7'h6F, 0, "R8");
    cyc(0, 0, 7'h00, 0, "R8");
    cyc(0, 0, 7'h5F, 0, "R6");

    // completion and new command in the same cycle
    cyc(1, 1, 7'h62, 8'h22);
    while (!(m_busy != 0 && m_cnt == m_dur - 1)) cyc(0, 0, 7'h62, 0);
    cyc(1, 1, 7'h62, 8'h31, "R8");
    chk(busy == 1'b0, "R8", busy, 0);
    cyc(1, 1, 7'h62, 8'h31, "R7");
    chk(busy == 1'b1, "R7", busy, 1);
    wait_idle();

    // R1 reload after a second reset
    @(negedge clk);
    do_reset();
    wait_idle();
    sweep("R1");

    summary();
    $finish;
  end
endmodule